// File: doc/BRIEF.md
# Burst SRAM Byte-Write and Output Control

This block is the data side of a synchronous burst memory whose words are split into four byte lanes of nine bits each: eight data bits plus one parity bit. An address front end outside the block delivers, once per clock, a registered access: a select flag and a word address. From the write controls sampled on the same edge, the block decides which lanes of that word are written. Those controls are an active-low global write, an active-low byte write enable and four active-low lane selects.

Write data is taken from the data bus into an input register on the edge that registers the write. Only the enabled lanes are committed to the array on the following edge. A read that arrives while that commit is still pending takes the pending lanes over the array contents.

The block also decides whether it drives the bidirectional data bus. The output enable and the sleep input act combinationally and are never sampled by the clock. The drive is also cut in three cycle-based cases: the data cycle of a write, the first access cycle after a deselected period, and any deselected cycle. A small behavioural array is included so that the block can be tested end to end.

Top module: `burst_sram_dctl`

## Requirements
- R1: With `gw_n` low on a selected edge, all four lanes of the addressed word are written, whatever `bwe_n` and `bws_n` are.
- R2: With `gw_n` high and `bwe_n` low, lane i (bits 9i+8..9i) is written only when `bws_n[i]` is low; the other lanes keep their contents.
- R3: The parity bit of lane i (bit 9i+8) is written together with data bits 9i+7..9i, under the same `bws_n[i]`.
- R4: With both `gw_n` and `bwe_n` high, a selected edge is a read and no lane is written, whatever `bws_n` is.
- R5: After the edge that registers a read, `dq_out` holds the addressed word. This includes any write registered on the edge before.
- R6: `oe_n` high forces `dq_oe` low in the same cycle, with no clock edge needed.
- R7: In the cycle after an edge that registers a write, `dq_oe` is low.
- R8: In the cycle after the first selected edge that follows a deselected edge, `dq_oe` is low.
- R9: In the cycle after a deselected edge, `dq_oe` is low.
- R10: While `zz` is high, `dq_oe` is low at once. Accesses sampled while `zz` is high are treated as deselected and write nothing, so stored data is unchanged after `zz` is released.
- R11: While `rst_n` is low, `dq_oe` is low. The state after reset counts as deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Registered access select from the address front end |
| addr_i | input | AW | Registered word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bws_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| zz | input | 1 | Sleep, active high, combinational |
| dq_in | input | 36 | Data bus as seen at the pins (input direction) |
| dq_out | output | 36 | Read data to the pins |
| dq_oe | output | 1 | Pin drive enable |

## Verification
A write commit and a read of the same word can fall in the same cycle. This happens when a write is registered on one edge and a read of that address on the next edge, while the lanes are still in the input register. Directed back-to-back sequences and random bursts over a narrow address range provoke this case. Each read is judged against a bench model that applied the masked write at once. A second overlap, between a combinational output-enable or sleep change and a registered drive decision, is provoked by toggling those inputs in the middle of a driven read cycle.

// File: rtl/bsdc_pkg.sv
package bsdc_pkg;
    localparam int LANES   = 4;
    localparam int DBITS   = 8;
    localparam int LANE_W  = DBITS + 1;
    localparam int WORD_W  = LANES * LANE_W;
    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bsdc_lane_dec.sv
module bsdc_lane_dec
    import bsdc_pkg::*;
(
    input  logic       gw_n,
    input  logic       bwe_n,
    input  lane_mask_t bws_n,
    output logic       wr_req,
    output lane_mask_t mask
);
    assign wr_req = !gw_n || !bwe_n;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = !gw_n || (!bwe_n && !bws_n[i]);
    end
endmodule

// File: rtl/bsdc_array.sv
module bsdc_array
    import bsdc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  lane_mask_t    wmask,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[i]) begin
                mem[waddr] <= wdata[i*LANE_W +: LANE_W];
            end
        end

        assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/bsdc_out_gate.sv
module bsdc_out_gate (
    input  logic oe_n,
    input  logic zz,
    input  logic rst_n,
    input  logic drv_q,
    output logic dq_oe
);
    assign dq_oe = rst_n && drv_q && !oe_n && !zz;
endmodule

// File: rtl/burst_sram_dctl.sv
module burst_sram_dctl
    import bsdc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [3:0]    bws_n,
    input  logic          oe_n,
    input  logic          zz,
    input  logic [35:0]   dq_in,
    output logic [35:0]   dq_out,
    output logic          dq_oe
);
    typedef struct packed {
        logic          act;
        logic          drv;
        word_t         rd;
        logic          pend;
        logic [AW-1:0] paddr;
        lane_mask_t    pmask;
        word_t         pdata;
    } state_t;

    state_t     s_d, s_q;
    logic       wr_req;
    lane_mask_t dec_mask;
    word_t      arr_rdata;

    bsdc_lane_dec u_dec (
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bws_n  (bws_n),
        .wr_req (wr_req),
        .mask   (dec_mask)
    );

    bsdc_array #(.AW(AW)) u_arr (
        .clk   (clk),
        .we    (s_q.pend),
        .waddr (s_q.paddr),
        .wmask (s_q.pmask),
        .wdata (s_q.pdata),
        .raddr (addr_i),
        .rdata (arr_rdata)
    );

    always_comb begin
        logic  act, wr;
        word_t merged;
        s_d    = s_q;
        act    = sel_i && !zz;
        wr     = act && wr_req;
        merged = arr_rdata;
        if (s_q.pend && s_q.paddr == addr_i) begin
            for (int i = 0; i < LANES; i++) begin
                if (s_q.pmask[i]) begin
                    merged[i*LANE_W +: LANE_W] = s_q.pdata[i*LANE_W +: LANE_W];
                end
            end
        end
        s_d.act   = act;
        s_d.drv   = act && !wr && s_q.act;
        s_d.pend  = wr;
        s_d.paddr = addr_i;
        s_d.pmask = dec_mask;
        s_d.pdata = dq_in;
        if (act && !wr) begin
            s_d.rd = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dq_out = s_q.rd;

    bsdc_out_gate u_gate (
        .oe_n  (oe_n),
        .zz    (zz),
        .rst_n (rst_n),
        .drv_q (s_q.drv),
        .dq_oe (dq_oe)
    );
endmodule

// File: rtl/burst_sram_dctl_chk.sv
module burst_sram_dctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_i,
    input logic       gw_n,
    input logic       bwe_n,
    input logic       oe_n,
    input logic       zz,
    input logic       dq_oe,
    input logic [3:0] dec_mask
);
    p_gw_all_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |-> dec_mask == 4'hF);

    p_no_lane_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |-> dec_mask == 4'h0);

    p_oe_masks_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_write_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !zz && (!gw_n || !bwe_n)) |=> !dq_oe);

    p_first_after_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !$past(sel_i)) |=> !dq_oe);

    p_desel_tristate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !dq_oe);

    p_sleep_tristate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> !dq_oe);

    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r11: assert (!dq_oe);
        end
    end
endmodule

bind burst_sram_dctl burst_sram_dctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .oe_n     (oe_n),
    .zz       (zz),
    .dq_oe    (dq_oe),
    .dec_mask (dec_mask)
);

// File: tb/tb_burst_sram_dctl.sv
module tb_burst_sram_dctl;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel_i;
    logic [AW-1:0] addr_i;
    logic          gw_n, bwe_n, oe_n, zz;
    logic [3:0]    bws_n;
    logic [35:0]   dq_in;
    logic [35:0]   dq_out;
    logic          dq_oe;

    logic [35:0] model [DEPTH];
    bit          prev_act;
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    bit          done   = 0;

    always #10 clk = ~clk;

    burst_sram_dctl #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i),
        .gw_n(gw_n), .bwe_n(bwe_n), .bws_n(bws_n), .oe_n(oe_n), .zz(zz),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [3:0] exp_mask(logic g, logic b, logic [3:0] bs);
        if (!g) return 4'hF;
        if (!b) return ~bs;
        return 4'h0;
    endfunction

    function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] m);
        logic [35:0] r = old;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        end
        return r;
    endfunction

    task automatic chk_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dq_oe actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(logic s, logic [AW-1:0] a, logic g, logic b, logic [3:0] bs,
                        logic [35:0] wd, logic z, logic o, string tag);
        logic        act, wr;
        logic [35:0] expd;
        bit          exp_drv;
        string       why;
        sel_i = s; addr_i = a; gw_n = g; bwe_n = b; bws_n = bs;
        dq_in = wd; zz = z; oe_n = o;
        act     = s && !z;
        wr      = act && (!g || !b);
        expd    = model[a];
        exp_drv = act && !wr && prev_act && !o && !z;
        if (z)             why = "R10";
        else if (o)        why = "R6";
        else if (!act)     why = "R9";
        else if (wr)       why = "R7";
        else if (!prev_act) why = "R8";
        else               why = "R5";
        @(posedge clk);
        @(negedge clk);
        chk_bit(why, dq_oe, exp_drv);
        if (exp_drv) begin
            checks++;
            if (dq_out !== expd) begin
                fails++;
                $display("FAIL %s: addr %0d dq_out actual %h expected %h", tag, a, dq_out, expd);
            end
        end
        if (wr) model[a] = merge(model[a], wd, exp_mask(g, b, bs));
        prev_act = act;
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        step(1'b1, a, 1'b1, 1'b1, 4'hF, 36'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b1, 1'b1, 4'hF, 36'h0, 1'b0, 1'b0, "R9");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                fails++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [AW-1:0] ba;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; sel_i = 1'b0; addr_i = '0; gw_n = 1'b1; bwe_n = 1'b1;
        bws_n = 4'hF; oe_n = 1'b0; zz = 1'b0; dq_in = '0; prev_act = 0;
        repeat (3) @(negedge clk);
        chk_bit("R11", dq_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill every word with global writes (byte enables deliberately inactive)
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b1, a[AW-1:0], 1'b0, 1'b1, 4'hF, {$urandom(), $urandom()}, 1'b0, 1'b0, "R1");
        end
        idle();
        rd(5, "R8");
        rd(5, "R1");
        // R1 with byte controls contradicting
        step(1'b1, 6, 1'b0, 1'b0, 4'hF, 36'hA_BCDE_F012, 1'b0, 1'b0, "R1");
        rd(6, "R1");
        // R2: lanes 0 and 2 only
        step(1'b1, 7, 1'b1, 1'b0, 4'b1010, 36'hF_FFFF_FFFF, 1'b0, 1'b0, "R2");
        rd(7, "R2");
        // R3: parity bits follow lanes 0..2, lane 3 untouched
        step(1'b1, 8, 1'b1, 1'b0, 4'b1000, 36'h8_0604_0201, 1'b0, 1'b0, "R3");
        rd(8, "R3");
        // R4: selects low but no enable
        step(1'b1, 9, 1'b1, 1'b1, 4'h0, 36'h0, 1'b0, 1'b0, "R4");
        rd(9, "R4");
        // R5: write then immediate read of same word (pending-commit bypass)
        step(1'b1, 10, 1'b1, 1'b0, 4'b0110, 36'h1_2345_6789, 1'b0, 1'b0, "R5");
        rd(10, "R5");
        step(1'b1, 10, 1'b0, 1'b1, 4'hF, 36'h9_8765_4321, 1'b0, 1'b0, "R5");
        step(1'b1, 10, 1'b1, 1'b0, 4'b1110, 36'h0_0000_0155, 1'b0, 1'b0, "R5");
        rd(10, "R5");
        // R6: output enable acts without a clock
        rd(11, "R5");
        oe_n = 1'b1; #1 chk_bit("R6", dq_oe, 1'b0);
        oe_n = 1'b0; #1 chk_bit("R6", dq_oe, 1'b1);
        // R10: sleep cuts drive at once, blocks writes, preserves data
        zz = 1'b1; #1 chk_bit("R10", dq_oe, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 12, 1'b0, 1'b0, 4'h0, {$urandom(), $urandom()}, 1'b1, 1'b0, "R10");
        end
        rd(12, "R10");
        rd(12, "R10");

        // random mix of single accesses and 4-beat bursts
        for (int n = 0; n < 400; n++) begin
            logic s, g, b, z, o;
            s = ($urandom_range(99) < 88);
            z = ($urandom_range(99) < 4);
            o = ($urandom_range(99) < 8);
            ba = $urandom_range(15);
            for (int k = 0; k < (($urandom_range(1) == 1) ? 4 : 1); k++) begin
                g = ($urandom_range(99) < 15) ? 1'b0 : 1'b1;
                b = ($urandom_range(99) < 40) ? 1'b0 : 1'b1;
                step(s, {ba[AW-1:2], ba[1:0] + 2'(k)}, g, b, 4'($urandom()),
                     {$urandom(), $urandom()}, z, o, "R5");
            end
        end
        // final read-back of the whole array
        for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0], "R5");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule